// File: doc/BRIEF.md
# Two-Dimensional Mesh Dimension-Order Port Selector

This block picks the output port for a head flit entering a router of a two-dimensional mesh. It is given the router's own column and row, together with the destination column and row carried in the head flit, and a strobe that marks the head as present. One clock later it presents a one-hot choice among five ports: the local processor port and the four compass directions. A valid pulse accompanies the choice.

Routing is dimension-ordered. The column difference is removed completely before the row difference is considered. The sign of each difference names the direction directly. Because every route turns at most once, and always from the X axis to the Y axis, the routes carry no cyclic channel dependence. Only head flits are presented to the block. The body and tail of a packet follow whatever port the head obtained.

Top module: `mesh_dor_route`

## Requirements
- R1: While reset is asserted, and after reset until the first head strobe has been registered, `route_vld` is 0 and `port_sel` is 0.
- R2: Offsets are signed differences, destination minus current, taken per dimension on unsigned coordinates. When `dst_x` is greater than `cur_x`, the east port is selected (`port_sel` = 5'b00010, bit 1).
- R3: When `dst_x` is less than `cur_x`, the west port is selected (`port_sel` = 5'b00100, bit 2).
- R4: When `dst_x` equals `cur_x` and `dst_y` is greater than `cur_y`, the north port is selected (`port_sel` = 5'b01000, bit 3).
- R5: When `dst_x` equals `cur_x` and `dst_y` is less than `cur_y`, the south port is selected (`port_sel` = 5'b10000, bit 4).
- R6: When both coordinates are equal, the local port is selected (`port_sel` = 5'b00001, bit 0).
- R7: Whenever the X offset is nonzero, the choice is east or west regardless of the Y offset. North or south is never selected before X is corrected.
- R8: `route_vld` is high exactly in the cycle after a clock edge that samples `head_vld` high, so there is one pulse per strobe. After an edge that samples `head_vld` low, `route_vld` is 0 and `port_sel` is 0, whatever the coordinate inputs were.
- R9: Whenever `route_vld` is high, `port_sel` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld | input | 1 | Head flit present; coordinates are sampled at this edge |
| cur_x | input | COORD_W | Column of this router |
| cur_y | input | COORD_W | Row of this router |
| dst_x | input | COORD_W | Destination column from the head flit |
| dst_y | input | COORD_W | Destination row from the head flit |
| port_sel | output | 5 | One-hot port: bit0 local, bit1 east, bit2 west, bit3 north, bit4 south |
| route_vld | output | 1 | High for one cycle when `port_sel` holds a decision |

## Verification
Every combination of current and destination coordinates on a 3-bit mesh is applied as a back-to-back stream of strobes. This stream tells apart the five sign cases of the offsets, and the cases where X is nonzero while Y points elsewhere, which expose a wrong dimension order. It also covers the extreme corners (0 against 7), which expose an offset taken unsigned or too narrow. Idle cycles with changing coordinates show that no strobe means no decision. Alternating strobe and idle cycles show that each decision stays valid for a single cycle.

// File: rtl/mesh_dor_route.sv
module mesh_dor_route #(
  parameter int COORD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_vld,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [4:0]         port_sel,
  output logic               route_vld
);
  localparam int OFS_W   = COORD_W + 1;
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;

  logic signed [OFS_W-1:0] off_x, off_y;
  logic [4:0] pick;

  assign off_x = $signed({1'b0, dst_x}) - $signed({1'b0, cur_x});
  assign off_y = $signed({1'b0, dst_y}) - $signed({1'b0, cur_y});

  always_comb begin
    pick = '0;
    if (off_x > 0)      pick[P_EAST]  = 1'b1;
    else if (off_x < 0) pick[P_WEST]  = 1'b1;
    else if (off_y > 0) pick[P_NORTH] = 1'b1;
    else if (off_y < 0) pick[P_SOUTH] = 1'b1;
    else                pick[P_LOCAL] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_vld <= 1'b0;
      port_sel  <= '0;
    end else begin
      route_vld <= head_vld;
      port_sel  <= head_vld ? pick : '0;
    end
  end
endmodule

// File: rtl/mesh_dor_route_chk.sv
module mesh_dor_route_chk #(
  parameter int COORD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               head_vld,
  input logic [COORD_W-1:0] cur_x,
  input logic [COORD_W-1:0] cur_y,
  input logic [COORD_W-1:0] dst_x,
  input logic [COORD_W-1:0] dst_y,
  input logic [4:0]         port_sel,
  input logic               route_vld
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!route_vld && port_sel == '0));

  p_one_pulse_per_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    route_vld == $past(head_vld));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !route_vld |-> port_sel == '0);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    route_vld |-> $countones(port_sel) == 1);

  p_east_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (route_vld && $past(dst_x) > $past(cur_x)) |-> port_sel[1]);

  p_west_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (route_vld && $past(dst_x) < $past(cur_x)) |-> port_sel[2]);

  p_x_first_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (route_vld && $past(dst_x) != $past(cur_x)) |-> port_sel[4:3] == 2'b00);

  p_local_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (route_vld && $past(dst_x) == $past(cur_x) && $past(dst_y) == $past(cur_y)) |-> port_sel[0]);
endmodule

bind mesh_dor_route mesh_dor_route_chk #(.COORD_W(COORD_W)) chk_i (.*);

// File: tb/mesh_dor_route_tb_top.sv
`timescale 1ns/1ps
module mesh_dor_route_tb_top;
  localparam int CW = 3;
  localparam int N  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          head_vld = 1'b0;
  logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [4:0]    port_sel;
  logic          route_vld;

  int   n_vec = 0;
  int   n_bad = 0;
  logic       exp_vld = 1'b0;
  logic [4:0] exp_port = '0;
  string      exp_tag = "R1";

  always #5 clk = ~clk;

  mesh_dor_route #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .head_vld(head_vld),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .port_sel(port_sel), .route_vld(route_vld)
  );

  function automatic logic [4:0] ref_port(int cx, int cy, int tx, int ty);
    if (tx > cx) return 5'b00010;
    if (tx < cx) return 5'b00100;
    if (ty > cy) return 5'b01000;
    if (ty < cy) return 5'b10000;
    return 5'b00001;
  endfunction

  function automatic string ref_tag(int cx, int cy, int tx, int ty);
    if (tx != cx && ty != cy) return (tx > cx) ? "R7/R2" : "R7/R3";
    if (tx > cx) return "R2";
    if (tx < cx) return "R3";
    if (ty > cy) return "R4";
    if (ty < cy) return "R5";
    return "R6";
  endfunction

  task automatic compare();
    n_vec++;
    if (route_vld !== exp_vld || port_sel !== exp_port) begin
      n_bad++;
      $display("FAIL %s: vld=%b port=%b expected vld=%b port=%b",
               exp_tag, route_vld, port_sel, exp_vld, exp_port);
    end else if (route_vld && $countones(port_sel) != 1) begin
      n_bad++;
      $display("FAIL R9: port=%b not one-hot, expected one bit", port_sel);
    end
  endtask

  task automatic step(input logic v, input int cx, input int cy, input int tx, input int ty);
    @(negedge clk);
    compare();
    head_vld = v;
    cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(tx); dst_y = CW'(ty);
    exp_vld  = v;
    exp_port = v ? ref_port(cx, cy, tx, ty) : 5'b0;
    exp_tag  = v ? ref_tag(cx, cy, tx, ty) : "R8";
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    head_vld = 1'b1;
    dst_x = 3'd5;
    repeat (3) @(negedge clk);
    exp_tag = "R1";
    compare();
    head_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    for (int cx = 0; cx < N; cx++)
      for (int cy = 0; cy < N; cy++)
        for (int tx = 0; tx < N; tx++)
          for (int ty = 0; ty < N; ty++)
            step(1'b1, cx, cy, tx, ty);

    for (int k = 0; k < 24; k++)
      step(1'b0, k % N, (k * 3) % N, (k * 5 + 1) % N, (k * 7 + 2) % N);

    for (int k = 0; k < 32; k++)
      step(k[0], (k * 5) % N, (k * 3 + 1) % N, (k * 7) % N, (k + 4) % N);

    step(1'b1, 0, 0, N - 1, N - 1);
    step(1'b1, N - 1, N - 1, 0, 0);
    step(1'b1, 0, N - 1, 0, 0);
    step(1'b1, 3, 0, 3, N - 1);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule